// File: doc/BRIEF.md
# Serial Receive Idle Timeout Detector

This block watches the already-filtered level of a serial receive line and raises a sticky interrupt flag once that line has stayed at its idle-high level for a programmed number of bit periods. The baud generator supplies a one-cycle strobe per bit period. The block counts these strobes while the line is high. The programmed value is a unit count, and each unit is worth four bit periods. A low level on the line at any time throws the count away.

Software programs the unit count through a register that lives outside this block. The block sees the register contents together with a one-cycle strobe that marks each write. A write clears the interrupt flag and starts a fresh measurement. After expiry the count parks until the line drops, so the block does not raise the same timeout a second time. A unit count of zero turns detection off.

Top module: `rx_idle_timeout`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `timeout_irq` is 0 and the count is zero.
- R2: The count advances by exactly one on each cycle where `bit_tick` is 1 and `rx_filt` is 1. Cycles without `bit_tick` leave it unchanged.
- R3: With unit count N (N > 0) on `rto_val`, `timeout_irq` becomes 1 in the cycle after the 4*N-th counted tick. It is still 0 after 4*N-1 ticks.
- R4: Once set, `timeout_irq` stays 1 whatever `rx_filt` and `bit_tick` do, until a write strobe arrives.
- R5: A cycle with `rto_wr` = 1 clears `timeout_irq` in the next cycle and restarts the count from zero.
- R6: Any cycle with `rx_filt` = 0 returns the count to zero, so only an unbroken high stretch can expire.
- R7: After expiry the count is held. Further ticks cause no second expiry until the line goes low or the register is written.
- R8: With `rto_val` = 0 the timeout never fires, however many high ticks arrive.
- R9: The count is wide enough for 4 times the largest unit count without wrapping. With `rto_val` = 255 the flag rises after exactly 1020 ticks.
- R10: If a write strobe falls in the same cycle as the terminal tick, the write wins: `timeout_irq` stays 0 and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_filt | input | 1 | Filtered serial receive level (1 = idle) |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| rto_val | input | RTO_W | Timeout unit count from the register |
| rto_wr | input | 1 | One-cycle strobe when the timeout register is written |
| timeout_irq | output | 1 | Sticky receive-timeout interrupt flag |

## Verification
The hardest case to reach is the largest unit count. The flag must rise at exactly 1020 ticks, which shows that the counter neither wraps nor stops early. The bench gets there by programming 255 and driving a tick on every cycle for over a thousand cycles. It checks the flag on every one of those cycles.

A second narrow case is a register write that lands on the exact cycle of the terminal tick. The bench counts one tick short of expiry and then drives the write and the final tick together.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

   // Counter arming state: LIVE counts ticks, SPENT holds after an expiry.
   typedef enum logic {
      ARM_LIVE  = 1'b0,
      ARM_SPENT = 1'b1
   } arm_state_t;

   // Count width needed to hold units * ticks-per-unit without wrapping.
   function automatic int unsigned count_width(input int unsigned rto_w,
                                               input int unsigned per_unit);
      int unsigned extra;
      extra = (per_unit <= 1) ? 0 : $clog2(per_unit);
      return rto_w + extra;
   endfunction

endpackage

// File: rtl/rxto_limit.sv
module rxto_limit #(
   parameter int unsigned RTO_W          = 8,
   parameter int unsigned TICKS_PER_UNIT = 4,
   parameter int unsigned CNT_W          = 10
) (
   input  logic [RTO_W-1:0] rto_val,
   output logic [CNT_W-1:0] limit,
   output logic             enabled
);

   localparam bit IS_POW2 = (TICKS_PER_UNIT != 0) &&
                            ((TICKS_PER_UNIT & (TICKS_PER_UNIT - 1)) == 0);
   localparam int unsigned SHIFT = (TICKS_PER_UNIT <= 1) ? 0 : $clog2(TICKS_PER_UNIT);

   if (CNT_W < RTO_W + SHIFT) begin : g_bad_width
      $error("rxto_limit: CNT_W too narrow for the terminal count");
   end

   generate
      if (IS_POW2) begin : g_shift
         always_comb limit = CNT_W'(rto_val) << SHIFT;
      end else begin : g_mult
         always_comb limit = CNT_W'(rto_val) * CNT_W'(TICKS_PER_UNIT);
      end
   endgenerate

   always_comb enabled = (rto_val != '0);

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter
   import rxto_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_filt,
   input  logic             bit_tick,
   input  logic             rto_wr,
   input  logic [CNT_W-1:0] limit,
   input  logic             enabled,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   arm_state_t       arm_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_last;
   logic             counting;

   // Terminal when this tick would make the count equal to the limit.
   always_comb at_last  = (cnt_q == (limit - ONE));
   always_comb counting = rx_filt && !rto_wr && enabled &&
                          (arm_q == ARM_LIVE) && bit_tick;
   always_comb expire   = counting && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         arm_q <= ARM_LIVE;
      end else if (!rx_filt || rto_wr) begin
         cnt_q <= '0;
         arm_q <= ARM_LIVE;
      end else if (counting) begin
         if (at_last) begin
            cnt_q <= '0;
            arm_q <= ARM_SPENT;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

   // R6: a low line empties the count.
   p_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_filt |=> (cnt_q == '0));

   // R2: no tick, no write, line high: the count does not move.
   p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_filt && !bit_tick && !rto_wr) |=> $stable(cnt_q));

   // R7: once spent, further ticks on a high line do not expire again.
   p_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q == ARM_SPENT && rx_filt && !rto_wr) |=> (arm_q == ARM_SPENT && cnt_q == '0));

   // R9: the count never reaches or passes the limit.
   p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      enabled |-> (cnt_q < limit));

   // R8: a zero unit count never expires.
   p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |-> !expire);

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic rto_wr,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq <= 1'b0;
      else if (rto_wr) irq <= 1'b0;
      else if (expire) irq <= 1'b1;
   end

   // R5: a register write clears the flag.
   p_clear_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rto_wr |=> !irq);

   // R3: an expiry sets the flag on the following cycle.
   p_set_on_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq);

   // R4: the flag holds until a write.
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rto_wr) |=> irq);

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
   import rxto_pkg::*;
#(
   parameter int unsigned RTO_W          = 8,
   parameter int unsigned TICKS_PER_UNIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_filt,
   input  logic             bit_tick,
   input  logic [RTO_W-1:0] rto_val,
   input  logic             rto_wr,
   output logic             timeout_irq
);

   localparam int unsigned CNT_W = count_width(RTO_W, TICKS_PER_UNIT);

   if (RTO_W < 1) begin : g_bad_rto
      $error("rx_idle_timeout: RTO_W must be at least 1");
   end
   if (TICKS_PER_UNIT < 1) begin : g_bad_unit
      $error("rx_idle_timeout: TICKS_PER_UNIT must be at least 1");
   end

   logic [CNT_W-1:0] limit;
   logic             enabled;
   logic             expire;

   rxto_limit #(
      .RTO_W          (RTO_W),
      .TICKS_PER_UNIT (TICKS_PER_UNIT),
      .CNT_W          (CNT_W)
   ) u_limit (
      .rto_val (rto_val),
      .limit   (limit),
      .enabled (enabled)
   );

   rxto_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_filt  (rx_filt),
      .bit_tick (bit_tick),
      .rto_wr   (rto_wr),
      .limit    (limit),
      .enabled  (enabled),
      .expire   (expire)
   );

   rxto_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .rto_wr (rto_wr),
      .irq    (timeout_irq)
   );

   // R10: a write in the terminal cycle keeps the flag low.
   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rto_wr && rx_filt && bit_tick) |=> !timeout_irq);

endmodule

// File: tb/rx_idle_timeout_bench.sv
module rx_idle_timeout_bench;

   localparam int CLK_PERIOD = 10;
   localparam int RTO_W      = 8;
   localparam int PER_UNIT   = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_filt = 1'b1;
   logic             bit_tick = 1'b0;
   logic [RTO_W-1:0] rto_val = '0;
   logic             rto_wr = 1'b0;
   logic             timeout_irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Scoreboard queues: expected flag and the requirement each item checks.
   logic  exp_q[$];
   string tag_q[$];

   // Independent model of the requirements.
   int m_cnt   = 0;
   bit m_armed = 1'b1;
   bit m_irq   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_idle_timeout #(.RTO_W(RTO_W), .TICKS_PER_UNIT(PER_UNIT)) u_rx_idle_timeout (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_filt     (rx_filt),
      .bit_tick    (bit_tick),
      .rto_val     (rto_val),
      .rto_wr      (rto_wr),
      .timeout_irq (timeout_irq)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // Driver: applies one cycle of stimulus at the falling edge and pushes the
   // flag value expected after the next rising edge.
   task automatic step(input bit rx, input bit tick, input bit wr, input string tag);
      int lim;
      bit fire;
      @(negedge clk);
      rx_filt  = rx;
      bit_tick = tick;
      rto_wr   = wr;
      lim  = int'(rto_val) * PER_UNIT;
      fire = 1'b0;
      if (!rx || wr) begin
         m_cnt   = 0;
         m_armed = 1'b1;
      end else if (m_armed && lim != 0 && tick) begin
         if (m_cnt + 1 == lim) begin
            fire    = 1'b1;
            m_armed = 1'b0;
            m_cnt   = 0;
         end else begin
            m_cnt = m_cnt + 1;
         end
      end
      if (wr)        m_irq = 1'b0;
      else if (fire) m_irq = 1'b1;
      exp_q.push_back(m_irq);
      tag_q.push_back(tag);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, tag);
   endtask

   task automatic write_rto(input logic [RTO_W-1:0] v, input string tag);
      @(negedge clk);
      rto_val = v;
      step(1'b1, 1'b0, 1'b1, tag);
   endtask

   // Monitor: a quarter period after each rising edge, compare one item.
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
         logic  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_vec++;
         if (timeout_irq !== e) begin
            n_bad++;
            $display("FAIL %s: timeout_irq=%b expected %b at %0t", t, timeout_irq, e, $time);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      n_vec++;
      if (timeout_irq !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: timeout_irq=%b expected 0 in reset", timeout_irq);
      end
      rst_n = 1'b1;
      step(1'b1, 1'b0, 1'b0, "R1");

      // R3: unit count 1 -> four ticks
      write_rto(8'd1, "R5");
      ticks(3, "R3");
      ticks(1, "R3");
      // R4/R7: flag sticky, no double expiry while held
      ticks(6, "R4");
      step(1'b0, 1'b0, 1'b0, "R4");
      step(1'b1, 1'b1, 1'b0, "R7");

      // R5: write clears and restarts
      write_rto(8'd2, "R5");
      ticks(7, "R5");
      ticks(1, "R3");

      // R2: ticks spaced by idle cycles, unit count 3 -> 12 ticks
      write_rto(8'd3, "R5");
      for (int i = 0; i < 11; i++) begin
         step(1'b1, 1'b1, 1'b0, "R2");
         step(1'b1, 1'b0, 1'b0, "R2");
         step(1'b1, 1'b0, 1'b0, "R2");
      end
      step(1'b1, 1'b1, 1'b0, "R2");

      // R6: low level mid-count starts over
      write_rto(8'd1, "R5");
      ticks(3, "R6");
      step(1'b0, 1'b1, 1'b0, "R6");
      ticks(3, "R6");
      ticks(1, "R6");

      // R8: zero disables
      write_rto(8'd0, "R8");
      ticks(40, "R8");

      // R10: write together with the terminal tick
      write_rto(8'd2, "R5");
      ticks(7, "R10");
      step(1'b1, 1'b1, 1'b1, "R10");
      ticks(7, "R10");
      ticks(1, "R10");

      // R5: write while line low and flag set
      step(1'b0, 1'b0, 1'b1, "R5");

      // R9: largest unit count, 1020 ticks, no wrap
      write_rto(8'd255, "R5");
      ticks(1019, "R9");
      ticks(1, "R9");
      ticks(5, "R9");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule